// File: doc/BRIEF.md
# SD Command Issue and Init-Stream Unit

This block is the command-path front end of an SD/MMC host. Software-side logic writes a 32-bit argument and then a command word. The write of the command word starts the operation. The unit assembles the 48-bit command token, protects it with a CRC7 and shifts it out MSB first on the CMD line, one bit per card clock. It then listens on the CMD line for the card's reply. It stores the reply in four 32-bit response words and signals completion or a response timeout.

A mode flag in a small control register changes what a command write of value zero does. With the flag set, that write does not send a command. It drives the CMD line high for a burst of card clocks, which is the power-up clocking a card needs before its first command. Completion is signalled the same way as for a command. The card clock is a one-cycle strobe that a divider derives from the system clock. The unit drives and samples CMD only on that strobe.

Top module: `sdc_cmd_front`

## Requirements
- R1: A command carries the opcode in bits 29:24 of the command word. Its token is sent as 48 strobes with the CMD driver enabled, MSB first: a 0 start bit, a 1 direction bit, the 6-bit opcode, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, zero seed) over those first 40 bits, and a 1 end bit.
- R2: The response type in bits 17:16 selects what follows the token. The value 0 means no response, and the command completes straight after the token. The value 1 means a 136-bit response. The values 2 and 3 mean a 48-bit response.
- R3: A command-word write that arrives while an operation is in flight is ignored. The token on the line and the completion that follows belong only to the first command.
- R4: While control bit 1 is set, a command-word write of value 0 produces 80 strobes with CMD driven high and then completes. A nonzero command-word write sends a normal command whatever the state of the flag.
- R5: A 136-bit response consists of an 8-bit header and 128 further bits. Those 128 bits go to the response words, with bits 31:0 in resp0 and bits 127:96 in resp3.
- R6: A 48-bit response stores its bits 39:8 (the 32 bits after the start, direction and 6-bit index fields) into resp0. It leaves resp1 to resp3 unchanged.
- R7: The response start bit is a 0 sampled on CMD. If 64 consecutive samples after the token are all high, status bit 1 (timeout) is set and status bit 0 is not set. A start bit on the 64th sample is still accepted.
- R8: Status bit 0 (complete) is set when a command or init burst finishes normally. The status bits hold until the next operation is accepted, which clears both. cmd_done_o pulses for one cycle at the end of every operation.
- R9: After reset the unit is idle, the CMD driver is disabled with the line level high, and the status bits, response words and data flag are zero.
- R10: Bit 21 of the command word marks that a data phase follows. dat_pend_o is set when such a command completes normally. It is not set on a timeout, and it is cleared when the next operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 argument, 1 command word, 2 control |
| wr_data | input | 32 | Write data |
| cmd_in | input | 1 | CMD line level sampled from the card |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe_o | output | 1 | CMD driver enable |
| bit_tick_o | output | 1 | Card clock strobe, one cycle per card bit |
| busy_o | output | 1 | Operation in flight |
| cmd_done_o | output | 1 | One-cycle end-of-operation pulse |
| stat_o | output | 2 | Bit 0 complete, bit 1 response timeout |
| dat_pend_o | output | 1 | Completed command announced a data phase |
| resp0_o | output | 32 | Response word 0 |
| resp1_o | output | 32 | Response word 1 |
| resp2_o | output | 32 | Response word 2 |
| resp3_o | output | 32 | Response word 3 |

## Verification
The bench targets the edges of the response window. A start bit on the 64th sample must be accepted, and 64 high samples must end in a timeout. A counter that is off by one either drops a slow card or waits one clock too long. It checks that a short response after a long one leaves resp1 to resp3 untouched. A design that clears or shifts all words would corrupt a stored register value. It sends the init burst and a nonzero command with the flag set, and checks that the burst is exactly 80 clocks and that only a zero write triggers it. It also writes a second command in the middle of a token. A design that restarts or reloads would put a mixed token on the line.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam logic [1:0] ADDR_ARG  = 2'd0;
  localparam logic [1:0] ADDR_CMD  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam logic [1:0] RSP_NONE  = 2'd0;
  localparam logic [1:0] RSP_LONG  = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_TX,
    ST_WAIT,
    ST_RX
  } sdc_state_e;

  // CRC7, polynomial x^7 + x^3 + 1, zero seed, MSB first
  function automatic logic [6:0] crc7_40(input logic [39:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

endpackage

// File: rtl/sdc_tick.sv
module sdc_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt == CW'(DIV - 1));
      if (cnt == CW'(DIV - 1)) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdc_regs.sv
module sdc_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] arg_o,
  output logic         init_mode_o
);
  import sdc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_o       <= '0;
      init_mode_o <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_ARG)  arg_o       <= wr_data;
      if (wr_addr == ADDR_CTRL) init_mode_o <= wr_data[1];
    end
  end
endmodule

// File: rtl/sdc_resp_bank.sv
module sdc_resp_bank #(
  parameter int W     = 32,
  parameter int WORDS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_long,
  input  logic               ld_short,
  input  logic [W*WORDS-1:0] long_data,
  input  logic [W-1:0]       short_data,
  output logic [W*WORDS-1:0] resp_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        resp_o[g*W +: W] <= '0;
      end else if (ld_long) begin
        resp_o[g*W +: W] <= long_data[g*W +: W];
      end else if (ld_short && (g == 0)) begin
        resp_o[g*W +: W] <= short_data;
      end
    end
  end
endmodule

// File: rtl/sdc_cmd_front.sv
module sdc_cmd_front #(
  parameter int DIV       = 4,
  parameter int INIT_CLKS = 80,
  parameter int RESP_TO   = 64,
  parameter int W         = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [31:0]  wr_data,
  input  logic         cmd_in,
  output logic         cmd_o,
  output logic         cmd_oe_o,
  output logic         bit_tick_o,
  output logic         busy_o,
  output logic         cmd_done_o,
  output logic [1:0]   stat_o,
  output logic         dat_pend_o,
  output logic [31:0]  resp0_o,
  output logic [31:0]  resp1_o,
  output logic [31:0]  resp2_o,
  output logic [31:0]  resp3_o
);
  import sdc_pkg::*;

  localparam int TOK_W   = 48;
  localparam int LONG_W  = 136;
  localparam int PAY_W   = 4 * W;
  localparam int CW      = $clog2(LONG_W + INIT_CLKS + RESP_TO);

  sdc_state_e       state;
  logic             tick;
  logic [W-1:0]     arg_q;
  logic             init_mode;
  logic [TOK_W-1:0] tok;
  logic [CW-1:0]    cnt;
  logic [1:0]       rtype;
  logic             want_data;
  logic [PAY_W-2:0] rsh;
  logic [PAY_W-1:0] rx_next;
  logic [PAY_W-1:0] resp_flat;
  logic             cmd_wr;
  logic             rx_last;
  logic             ld_long;
  logic             ld_short;
  logic [39:0]      head;

  sdc_tick #(.DIV(DIV)) tick_i (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  sdc_regs #(.W(W)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .arg_o       (arg_q),
    .init_mode_o (init_mode)
  );

  assign cmd_wr  = wr_en && (wr_addr == ADDR_CMD);
  assign head    = {2'b01, wr_data[29:24], arg_q};
  assign rx_next = {rsh, cmd_in};
  assign rx_last = (rtype == RSP_LONG) ? (cnt == CW'(LONG_W - 1))
                                       : (cnt == CW'(TOK_W - 1));
  assign ld_long  = (state == ST_RX) && tick && rx_last && (rtype == RSP_LONG);
  assign ld_short = (state == ST_RX) && tick && rx_last && (rtype != RSP_LONG);
  assign busy_o   = (state != ST_IDLE);

  sdc_resp_bank #(.W(W), .WORDS(4)) bank_i (
    .clk        (clk),
    .rst        (rst),
    .ld_long    (ld_long),
    .ld_short   (ld_short),
    .long_data  (rx_next),
    .short_data (rx_next[39:8]),
    .resp_o     (resp_flat)
  );

  assign resp0_o = resp_flat[31:0];
  assign resp1_o = resp_flat[63:32];
  assign resp2_o = resp_flat[95:64];
  assign resp3_o = resp_flat[127:96];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tok        <= '0;
      cnt        <= '0;
      rtype      <= RSP_NONE;
      want_data  <= 1'b0;
      rsh        <= '0;
      cmd_o      <= 1'b1;
      cmd_oe_o   <= 1'b0;
      bit_tick_o <= 1'b0;
      cmd_done_o <= 1'b0;
      stat_o     <= 2'b00;
      dat_pend_o <= 1'b0;
    end else begin
      cmd_done_o <= 1'b0;
      bit_tick_o <= tick;
      unique case (state)
        ST_IDLE: begin
          if (cmd_wr) begin
            stat_o     <= 2'b00;
            dat_pend_o <= 1'b0;
            cnt        <= '0;
            want_data  <= wr_data[21];
            rtype      <= wr_data[17:16];
            if (init_mode && (wr_data == '0)) begin
              state <= ST_INIT;
            end else begin
              tok   <= {head, crc7_40(head), 1'b1};
              state <= ST_TX;
            end
          end
        end
        ST_INIT: begin
          if (tick) begin
            if (cnt == CW'(INIT_CLKS)) begin
              cmd_oe_o   <= 1'b0;
              stat_o     <= 2'b01;
              cmd_done_o <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              cmd_oe_o <= 1'b1;
              cmd_o    <= 1'b1;
              cnt      <= cnt + 1'b1;
            end
          end
        end
        ST_TX: begin
          if (tick) begin
            if (cnt == CW'(TOK_W)) begin
              cmd_oe_o <= 1'b0;
              cmd_o    <= 1'b1;
              cnt      <= '0;
              if (rtype == RSP_NONE) begin
                stat_o     <= 2'b01;
                cmd_done_o <= 1'b1;
                dat_pend_o <= want_data;
                state      <= ST_IDLE;
              end else begin
                state <= ST_WAIT;
              end
            end else begin
              cmd_oe_o <= 1'b1;
              cmd_o    <= tok[TOK_W-1];
              tok      <= {tok[TOK_W-2:0], 1'b0};
              cnt      <= cnt + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (tick) begin
            if (!cmd_in) begin
              rsh   <= '0;
              cnt   <= CW'(1);
              state <= ST_RX;
            end else if (cnt == CW'(RESP_TO - 1)) begin
              stat_o     <= 2'b10;
              cmd_done_o <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_RX: begin
          if (tick) begin
            rsh <= rx_next[PAY_W-2:0];
            cnt <= cnt + 1'b1;
            if (rx_last) begin
              stat_o     <= 2'b01;
              cmd_done_o <= 1'b1;
              dat_pend_o <= want_data;
              state      <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdc_cmd_front_chk.sv
module sdc_cmd_front_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy_o,
  input logic        cmd_o,
  input logic        cmd_oe_o,
  input logic        cmd_done_o,
  input logic [1:0]  stat_o,
  input logic        dat_pend_o,
  input logic [31:0] resp1_o
);
  // R9
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!cmd_oe_o && cmd_o));

  // R1
  drive_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_oe_o |-> busy_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_done_o |-> (!busy_o && ($countones(stat_o) == 1)));

  // R8
  accept_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (stat_o == 2'b00 && !dat_pend_o));

  // R7
  stat_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    stat_o != 2'b11);

  // R10
  dat_needs_cc_chk: assert property (@(posedge clk) disable iff (rst)
    dat_pend_o |-> stat_o[0]);

  // R6
  resp1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_done_o |-> $stable(resp1_o));
endmodule

bind sdc_cmd_front sdc_cmd_front_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .busy_o     (busy_o),
  .cmd_o      (cmd_o),
  .cmd_oe_o   (cmd_oe_o),
  .cmd_done_o (cmd_done_o),
  .stat_o     (stat_o),
  .dat_pend_o (dat_pend_o),
  .resp1_o    (resp1_o)
);

// File: tb/sdc_cmd_front_tb.sv
module sdc_cmd_front_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cmd_in = 1'b1;
  logic        cmd_o, cmd_oe_o, bit_tick_o, busy_o, cmd_done_o, dat_pend_o;
  logic [1:0]  stat_o;
  logic [31:0] resp0_o, resp1_o, resp2_o, resp3_o;

  always #4 clk = ~clk;

  sdc_cmd_front dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_in(cmd_in), .cmd_o(cmd_o), .cmd_oe_o(cmd_oe_o), .bit_tick_o(bit_tick_o),
    .busy_o(busy_o), .cmd_done_o(cmd_done_o), .stat_o(stat_o), .dat_pend_o(dat_pend_o),
    .resp0_o(resp0_o), .resp1_o(resp1_o), .resp2_o(resp2_o), .resp3_o(resp3_o)
  );

  int checks = 0;
  int fails  = 0;

  // bench state of one operation
  logic [47:0] got_tok;
  int          got_n;
  bit          all_high;
  bit          done_seen;
  logic [31:0] m_resp [4];

  // {command word, argument, leading high samples, payload}
  localparam logic [127:0] VEC [6] = '{
    {32'h0802_0000, 32'h0000_01AA, 32'd3,  32'h0000_01AA},
    {32'h0201_0000, 32'h0000_0000, 32'd5,  32'hDEAD_BEEF},
    {32'h3702_0000, 32'h1234_0000, 32'd0,  32'h0000_0120},
    {32'h0CC3_0000, 32'h0000_0000, 32'd10, 32'h0000_0B00},
    {32'h1122_0000, 32'h0000_0200, 32'd63, 32'h0000_0900},
    {32'h0700_0000, 32'h0001_0000, 32'd0,  32'h0000_0000}
  };

  function automatic logic [6:0] calc_crc(input logic [39:0] d);
    logic [6:0] r = 7'd0;
    for (int k = 0; k < 40; k++) begin
      logic b;
      b = d[39-k] ^ r[6];
      r = {r[5:3], r[2] ^ b, r[1:0], b};
    end
    return r;
  endfunction

  function automatic logic [47:0] exp_token(input logic [5:0] op, input logic [31:0] a);
    return {2'b01, op, a, calc_crc({2'b01, op, a}), 1'b1};
  endfunction

  function automatic logic [127:0] long_body(input logic [31:0] p);
    return {p, ~p, p ^ 32'h5A5A_5A5A, p[30:0], 1'b1};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // issue one operation and play the card side
  task automatic run_op(input logic [31:0] cw, input logic [31:0] aw, input int dly,
                        input logic [135:0] frame, input int rlen, input bit poke);
    int k = 0;
    bit poked = 1'b0;
    got_tok = '0; got_n = 0; all_high = 1'b1; done_seen = 1'b0;
    wr(2'd0, aw);
    wr(2'd1, cw);
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (cmd_done_o) begin done_seen = 1'b1; break; end
      if (poke && !poked && got_n == 10) begin
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h3F01_0000; poked = 1'b1;
      end
      if (bit_tick_o) begin
        if (cmd_oe_o) begin
          got_tok = {got_tok[46:0], cmd_o};
          got_n++;
          if (!cmd_o) all_high = 1'b0;
        end else if (got_n > 0 && rlen > 0) begin
          if (k < dly) cmd_in = 1'b1;
          else if (k - dly < rlen) cmd_in = frame[rlen-1-(k-dly)];
          else cmd_in = 1'b1;
          k++;
        end
      end
    end
    wr_en = 1'b0;
    cmd_in = 1'b1;
  endtask

  task automatic check_resp(input string req);
    chk(resp0_o == m_resp[0], req, resp0_o, m_resp[0]);
    chk(resp1_o == m_resp[1], req, resp1_o, m_resp[1]);
    chk(resp2_o == m_resp[2], req, resp2_o, m_resp[2]);
    chk(resp3_o == m_resp[3], req, resp3_o, m_resp[3]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_resp[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!busy_o && !cmd_oe_o && cmd_o, "R9 line", {busy_o, cmd_oe_o, cmd_o}, 3'b001);
    chk(stat_o == 2'b00 && !dat_pend_o, "R9 status", {stat_o, dat_pend_o}, 0);
    check_resp("R9 resp");

    // table of commands: R1 R2 R5 R6 R7 R10
    for (int v = 0; v < 6; v++) begin
      logic [31:0] cw, aw, pl;
      int dly, rlen;
      logic [135:0] fr;
      cw = VEC[v][127:96]; aw = VEC[v][95:64]; dly = int'(VEC[v][63:32]); pl = VEC[v][31:0];
      fr = '0;
      if (cw[17:16] == 2'd1) begin
        rlen = 136;
        fr = {8'h3F, long_body(pl)};
      end else if (cw[17:16] == 2'd0) begin
        rlen = 0;
      end else begin
        rlen = 48;
        fr[47:0] = {2'b00, cw[29:24], pl, calc_crc({2'b00, cw[29:24], pl}), 1'b1};
      end
      run_op(cw, aw, dly, fr, rlen, 1'b0);
      chk(got_n == 48, "R1 token length", got_n, 48);
      chk(got_tok == exp_token(cw[29:24], aw), "R1 token", got_tok, exp_token(cw[29:24], aw));
      chk(done_seen && stat_o == 2'b01, "R2 R8 complete", {done_seen, stat_o}, 3'b101);
      if (rlen == 136) begin
        logic [127:0] b;
        b = long_body(pl);
        for (int i = 0; i < 4; i++) m_resp[i] = b[i*32 +: 32];
        check_resp("R5 long response");
      end else if (rlen == 48) begin
        m_resp[0] = pl;
        check_resp("R6 short response");
      end else begin
        check_resp("R2 no response");
      end
      chk(dat_pend_o == cw[21], "R10 data flag", dat_pend_o, cw[21]);
    end

    // R1 known token: opcode 0, argument 0, flag clear
    run_op(32'h0000_0000, 32'h0, 0, '0, 0, 1'b0);
    chk(got_tok == 48'h4000_0000_0095, "R1 R4 zero cmd no flag", got_tok, 48'h4000_0000_0095);

    // R4 init burst
    wr(2'd2, 32'h0000_0002);
    run_op(32'h0000_0000, 32'h0, 0, '0, 0, 1'b0);
    chk(got_n == 80 && all_high, "R4 init burst", {got_n, all_high}, {32'd80, 1'b1});
    chk(done_seen && stat_o == 2'b01, "R4 init complete", stat_o, 2'b01);
    check_resp("R4 resp untouched");

    // R4 nonzero write with flag set is a command
    run_op(32'h0800_0000, 32'h0000_01AA, 0, '0, 0, 1'b0);
    chk(got_tok == 48'h4800_0001_AA87, "R4 flag nonzero", got_tok, 48'h4800_0001_AA87);
    wr(2'd2, 32'h0);

    // R7 timeout after 64 high samples, data flag not set
    run_op(32'h1122_0000, 32'h0000_0200, 64,
           {88'h0, 2'b00, 6'd17, 32'h1111_2222, 7'h00, 1'b1}, 48, 1'b0);
    chk(done_seen && stat_o == 2'b10, "R7 timeout status", stat_o, 2'b10);
    chk(!dat_pend_o, "R10 R7 no data flag on timeout", dat_pend_o, 0);
    check_resp("R7 resp unchanged");
    repeat (200) @(negedge clk);
    chk(!busy_o, "R7 idle after timeout", busy_o, 0);

    // R3 command write during token ignored
    run_op(32'h0D00_0000, 32'hCAFE_0001, 0, '0, 0, 1'b1);
    chk(got_tok == exp_token(6'd13, 32'hCAFE_0001), "R3 token kept", got_tok,
        exp_token(6'd13, 32'hCAFE_0001));
    repeat (40) @(negedge clk);
    chk(!busy_o && stat_o == 2'b01, "R3 no restart", {busy_o, stat_o}, 3'b001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule